// File: doc/BRIEF.md
# Configuration Address/Data Port Translator

This host-bridge block sits on a simple CPU I/O bus and exposes two 32-bit ports. The address port at I/O 0xCF8 holds a latched configuration address word. The data port at I/O 0xCFC turns each access into a configuration transaction on a simplified downstream interface. That interface carries the bus, device, function and register numbers, the byte enables and the write data.

For bus 0 the block drives one select line per device, decoded one-hot from the device number. For any other bus number it raises a forwarding flag and drives no select line. The downstream transaction stays open until the target acknowledges it. If no acknowledge arrives within the response window, the block ends the access itself as a master-abort. In that case the CPU still sees a normal completion: write data is dropped and reads return all ones.

The CPU raises `io_req` for one cycle and then waits for the one-cycle `io_done`, which carries `io_rdata` for reads.

Top module: `cfg_port_xlat`

## Requirements
- R1: After reset, `io_done`, `cfg_req`, `cfg_type1` and every `idsel` line are 0, and a read of the address port returns 0.
- R2: A write to the address port (0xCF8) updates, byte by byte under `io_be`, bit 31 (enable) and bits 23:2 (bus 23:16, device 15:11, function 10:8, register 7:2). Bits 30:24 and 1:0 always read back 0. A read of the address port returns the latched word. Both complete with `io_done` one cycle after `io_req`.
- R3: While address bit 31 is 0, an access to the data port (0xCFC) completes one cycle after `io_req` without raising `cfg_req`. A read returns 0xFFFFFFFF, and a write changes no state.
- R4: While address bit 31 is 1, an access to the data port raises `cfg_req`. The transaction carries the latched bus, device, function and register fields, the access's `io_be`, its direction on `cfg_wr`, and `io_wdata`.
- R5: For bus number 0, exactly `idsel[device]` is 1 while `cfg_req` is high and `cfg_type1` is 0. No `idsel` line is 1 while `cfg_req` is low.
- R6: For a nonzero bus number, `cfg_type1` is 1 and all `idsel` lines are 0 during the transaction.
- R7: If `cfg_ack` is 1 in any of the first 5 cycles that `cfg_req` is high, the access completes on the next cycle with `io_mabort` = 0. A read returns `cfg_rdata` as sampled with the acknowledge. `cfg_req` then falls.
- R8: If no acknowledge arrives in those 5 cycles, `cfg_req` falls after exactly 5 cycles. The access completes with `io_mabort` = 1 and `io_rdata` = 0xFFFFFFFF, and write data is dropped.
- R9: `io_done` is a single-cycle pulse. While `cfg_req` stays high, all downstream fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | One-cycle I/O access request |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | Byte enables, bit n for byte n |
| io_wdata | input | 32 | Write data |
| io_done | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Read data, valid with io_done |
| io_mabort | output | 1 | Completion was a master-abort |
| cfg_req | output | 1 | Configuration transaction in progress |
| cfg_wr | output | 1 | Transaction direction |
| cfg_bus | output | 8 | Bus number |
| cfg_dev | output | 5 | Device number |
| cfg_fn | output | 3 | Function number |
| cfg_reg | output | 6 | Register (dword) number |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data |
| cfg_type1 | output | 1 | Nonzero bus: forward to another bus |
| idsel | output | 32 | One-hot device select for bus 0 |
| cfg_ack | input | 1 | Target acknowledge |
| cfg_rdata | input | 32 | Target read data, valid with cfg_ack |

## Verification
The address port is first written with all ones and then with a single byte enable. This separates proper masking of the reserved bits from a full-word overwrite, and shows the per-byte update.

Data-port accesses are tried in three settings: with the enable clear, on bus 0 with low and high device numbers, and on a nonzero bus. These distinguish gating by the enable, the select decode and the forwarding flag.

Acknowledges are placed at delays 0, 1, 2 and 4, and one is withheld entirely. This pins the last cycle in which an acknowledge is still accepted against the master-abort path and its all-ones data.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;

    localparam logic [15:0] CFG_ADDR_IO = 16'hCF8;
    localparam logic [15:0] CFG_DATA_IO = 16'hCFC;

    // bits of the address word that are kept; the rest read as zero
    localparam logic [31:0] ADDR_KEEP_MASK = 32'h80FF_FFFC;

    // field positions inside the latched address word
    localparam int EN_BIT  = 31;
    localparam int BUS_LSB = 16;
    localparam int DEV_LSB = 11;
    localparam int FN_LSB  = 8;
    localparam int REG_LSB = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CFG
    } xlat_state_e;

    typedef struct packed {
        xlat_state_e  state;
        logic         done;
        logic         mabort;
        logic [31:0]  rdata;
        logic         req;
        logic         wr;
        logic [7:0]   bus;
        logic [4:0]   dev;
        logic [2:0]   fn;
        logic [5:0]   regn;
        logic [3:0]   be;
        logic [31:0]  wdata;
    } xlat_st_t;

endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
    import cfg_xlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] addr_q
);

    logic [31:0] addr_d;

    always_comb begin
        addr_d = addr_q;
        if (wr_en) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) addr_d[8*b +: 8] = wdata[8*b +: 8];
            end
        end
        addr_d = addr_d & ADDR_KEEP_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

endmodule

// File: rtl/cfg_idsel_dec.sv
module cfg_idsel_dec #(
    parameter int NUM_IDSEL = 32
) (
    input  logic                 req,
    input  logic [7:0]           bus,
    input  logic [4:0]           dev,
    output logic [NUM_IDSEL-1:0] idsel,
    output logic                 type1
);

    logic local_bus;

    assign local_bus = (bus == 8'd0);
    assign type1     = req && !local_bus;

    for (genvar g = 0; g < NUM_IDSEL; g++) begin : g_sel
        assign idsel[g] = req && local_bus && (dev == 5'(g));
    end

endmodule

// File: rtl/cfg_abort_timer.sv
module cfg_abort_timer #(
    parameter int TMO_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic last
);

    localparam int CW = $clog2(TMO_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)    cnt_d = '0;
        else if (run) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(TMO_CYC - 1));

endmodule

// File: rtl/cfg_port_xlat.sv
module cfg_port_xlat
    import cfg_xlat_pkg::*;
#(
    parameter int          NUM_IDSEL = 32,
    parameter int          TMO_CYC   = 5,
    parameter logic [15:0] ADDR_PORT = CFG_ADDR_IO,
    parameter logic [15:0] DATA_PORT = CFG_DATA_IO
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_req,
    input  logic                 io_wr,
    input  logic [15:0]          io_addr,
    input  logic [3:0]           io_be,
    input  logic [31:0]          io_wdata,
    output logic                 io_done,
    output logic [31:0]          io_rdata,
    output logic                 io_mabort,
    output logic                 cfg_req,
    output logic                 cfg_wr,
    output logic [7:0]           cfg_bus,
    output logic [4:0]           cfg_dev,
    output logic [2:0]           cfg_fn,
    output logic [5:0]           cfg_reg,
    output logic [3:0]           cfg_be,
    output logic [31:0]          cfg_wdata,
    output logic                 cfg_type1,
    output logic [NUM_IDSEL-1:0] idsel,
    input  logic                 cfg_ack,
    input  logic [31:0]          cfg_rdata
);

    localparam logic [31:0] ALL_ONES = '1;

    xlat_st_t    s_d, s_q;
    logic [31:0] addr_word;
    logic        hit_addr, hit_data, idle;
    logic        addr_wr_en, tmr_clear, tmr_run, tmr_last;

    assign idle       = (s_q.state == ST_IDLE);
    assign hit_addr   = (io_addr == ADDR_PORT);
    assign hit_data   = (io_addr == DATA_PORT);
    assign addr_wr_en = idle && io_req && io_wr && hit_addr;

    cfg_addr_reg i_addr_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (addr_wr_en),
        .be     (io_be),
        .wdata  (io_wdata),
        .addr_q (addr_word)
    );

    cfg_abort_timer #(.TMO_CYC(TMO_CYC)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .run   (tmr_run),
        .last  (tmr_last)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.mabort = 1'b0;
        tmr_clear  = 1'b0;
        tmr_run    = 1'b0;

        unique case (s_q.state)
            ST_IDLE: begin
                if (io_req) begin
                    if (hit_data && addr_word[EN_BIT]) begin
                        // open a downstream configuration transaction
                        s_d.state = ST_CFG;
                        s_d.req   = 1'b1;
                        s_d.wr    = io_wr;
                        s_d.bus   = addr_word[BUS_LSB +: 8];
                        s_d.dev   = addr_word[DEV_LSB +: 5];
                        s_d.fn    = addr_word[FN_LSB  +: 3];
                        s_d.regn  = addr_word[REG_LSB +: 6];
                        s_d.be    = io_be;
                        s_d.wdata = io_wdata;
                        tmr_clear = 1'b1;
                    end else begin
                        // address port, disabled data port or foreign address
                        s_d.done  = 1'b1;
                        s_d.rdata = (hit_addr && !io_wr) ? addr_word : ALL_ONES;
                    end
                end
            end
            ST_CFG: begin
                if (cfg_ack) begin
                    s_d.state = ST_IDLE;
                    s_d.req   = 1'b0;
                    s_d.done  = 1'b1;
                    s_d.rdata = s_q.wr ? '0 : cfg_rdata;
                end else if (tmr_last) begin
                    s_d.state  = ST_IDLE;
                    s_d.req    = 1'b0;
                    s_d.done   = 1'b1;
                    s_d.mabort = 1'b1;
                    s_d.rdata  = ALL_ONES;
                end else begin
                    tmr_run = 1'b1;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    cfg_idsel_dec #(.NUM_IDSEL(NUM_IDSEL)) i_idsel (
        .req   (s_q.req),
        .bus   (s_q.bus),
        .dev   (s_q.dev),
        .idsel (idsel),
        .type1 (cfg_type1)
    );

    assign io_done   = s_q.done;
    assign io_rdata  = s_q.rdata;
    assign io_mabort = s_q.mabort;
    assign cfg_req   = s_q.req;
    assign cfg_wr    = s_q.wr;
    assign cfg_bus   = s_q.bus;
    assign cfg_dev   = s_q.dev;
    assign cfg_fn    = s_q.fn;
    assign cfg_reg   = s_q.regn;
    assign cfg_be    = s_q.be;
    assign cfg_wdata = s_q.wdata;

endmodule

// File: rtl/cfg_port_xlat_chk.sv
module cfg_port_xlat_chk #(
    parameter int NUM_IDSEL = 32,
    parameter int TMO_CYC   = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 io_done,
    input logic [31:0]          io_rdata,
    input logic                 io_mabort,
    input logic                 cfg_req,
    input logic                 cfg_wr,
    input logic [7:0]           cfg_bus,
    input logic [4:0]           cfg_dev,
    input logic [2:0]           cfg_fn,
    input logic [5:0]           cfg_reg,
    input logic [3:0]           cfg_be,
    input logic [31:0]          cfg_wdata,
    input logic                 cfg_type1,
    input logic [NUM_IDSEL-1:0] idsel
);

    localparam int CW = $clog2(TMO_CYC + 2) + 1;

    logic [CW-1:0] req_run;

    always_ff @(posedge clk) begin
        if (!rst_n)       req_run <= '0;
        else if (cfg_req) req_run <= req_run + 1'b1;
        else              req_run <= '0;
    end

    a_r8_req_window: assert property (@(posedge clk) disable iff (!rst_n)
        req_run <= CW'(TMO_CYC));

    a_r8_abort_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (io_done && io_mabort) |-> (io_rdata == 32'hFFFF_FFFF));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        io_done |=> !io_done);

    a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && $past(cfg_req)) |->
        $stable({cfg_wr, cfg_bus, cfg_dev, cfg_fn, cfg_reg, cfg_be, cfg_wdata}));

    a_r5_idsel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_type1) |-> $onehot0(idsel));

    a_r5_idsel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req |-> (idsel == '0));

    a_r6_type1_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_type1 |-> (idsel == '0 && cfg_bus != 8'd0));

endmodule

bind cfg_port_xlat cfg_port_xlat_chk #(
    .NUM_IDSEL (NUM_IDSEL),
    .TMO_CYC   (TMO_CYC)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_done   (io_done),
    .io_rdata  (io_rdata),
    .io_mabort (io_mabort),
    .cfg_req   (cfg_req),
    .cfg_wr    (cfg_wr),
    .cfg_bus   (cfg_bus),
    .cfg_dev   (cfg_dev),
    .cfg_fn    (cfg_fn),
    .cfg_reg   (cfg_reg),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_type1 (cfg_type1),
    .idsel     (idsel)
);

// File: tb/test_cfg_port_xlat.sv
`timescale 1ns/1ps
module test_cfg_port_xlat;

    localparam logic [15:0] P_ADDR = 16'hCF8;
    localparam logic [15:0] P_DATA = 16'hCFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic        io_done, io_mabort;
    logic [31:0] io_rdata;
    logic        cfg_req, cfg_wr, cfg_type1;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [5:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] idsel;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int checks = 0;
    int errors = 0;

    // target model state
    int          ack_dly = 0;
    logic [31:0] resp_data = '0;
    int          starts = 0;
    int          req_cycles = 0;
    logic        seen = 1'b0;
    int          k = 0;
    logic        c_wr, c_type1;
    logic [7:0]  c_bus;
    logic [4:0]  c_dev;
    logic [2:0]  c_fn;
    logic [5:0]  c_reg;
    logic [3:0]  c_be;
    logic [31:0] c_wdata, c_idsel;

    always #4 clk = ~clk;

    cfg_port_xlat i_cfg_port_xlat (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr),
        .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
        .io_done(io_done), .io_rdata(io_rdata), .io_mabort(io_mabort),
        .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_bus(cfg_bus),
        .cfg_dev(cfg_dev), .cfg_fn(cfg_fn), .cfg_reg(cfg_reg),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_type1(cfg_type1),
        .idsel(idsel), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
    );

    // responder: acknowledges ack_dly cycles after cfg_req is first seen
    initial begin
        forever begin
            @(negedge clk);
            if (cfg_req) begin
                if (!seen) begin
                    seen = 1'b1; k = 0; starts++;
                    c_wr = cfg_wr; c_type1 = cfg_type1; c_bus = cfg_bus;
                    c_dev = cfg_dev; c_fn = cfg_fn; c_reg = cfg_reg;
                    c_be = cfg_be; c_wdata = cfg_wdata; c_idsel = idsel;
                end
                req_cycles++;
                cfg_ack   = (k == ack_dly);
                cfg_rdata = (k == ack_dly) ? resp_data : 32'h0;
                k++;
            end else begin
                seen = 1'b0; cfg_ack = 1'b0; cfg_rdata = '0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic io_access(input logic wr, input logic [15:0] addr,
                             input logic [3:0] be, input logic [31:0] wd,
                             output logic [31:0] rd, output logic ab, output int lat);
        @(negedge clk);
        io_req = 1'b1; io_wr = wr; io_addr = addr; io_be = be; io_wdata = wd;
        req_cycles = 0;
        @(negedge clk);
        io_req = 1'b0;
        lat = 1;
        while (!io_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        rd = io_rdata; ab = io_mabort;
    endtask

    function automatic logic [31:0] mk_addr(input bit en, input int bus, input int dev,
                                            input int fn, input int rg);
        return {en, 7'd0, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b00};
    endfunction

    task automatic t_reset();
        logic [31:0] rd; logic ab; int lat;
        check(!io_done && !cfg_req && !cfg_type1, "R1 idle outputs",
              {29'd0, io_done, cfg_req, cfg_type1}, 32'h0);
        check(idsel == '0, "R1 idsel", idsel, 32'h0);
        io_access(1'b0, P_ADDR, 4'hF, '0, rd, ab, lat);
        check(rd == 32'h0, "R1 address word after reset", rd, 32'h0);
    endtask

    task automatic t_addr_reg();
        logic [31:0] rd; logic ab; int lat;
        io_access(1'b1, P_ADDR, 4'hF, 32'hFFFF_FFFF, rd, ab, lat);
        check(lat == 1, "R2 write latency", 32'(lat), 32'd1);
        io_access(1'b0, P_ADDR, 4'hF, '0, rd, ab, lat);
        check(rd == 32'h80FF_FFFC, "R2 reserved bits zero", rd, 32'h80FF_FFFC);
        check(lat == 1, "R2 read latency", 32'(lat), 32'd1);
        io_access(1'b1, P_ADDR, 4'b0001, 32'h1234_5678, rd, ab, lat);
        io_access(1'b0, P_ADDR, 4'hF, '0, rd, ab, lat);
        check(rd == 32'h80FF_FF78, "R2 byte enable merge", rd, 32'h80FF_FF78);
    endtask

    task automatic t_disabled();
        logic [31:0] rd; logic ab; int lat; int s0;
        io_access(1'b1, P_ADDR, 4'hF, mk_addr(0, 0, 1, 0, 0), rd, ab, lat);
        s0 = starts;
        io_access(1'b0, P_DATA, 4'hF, '0, rd, ab, lat);
        check(rd == 32'hFFFF_FFFF, "R3 disabled read all ones", rd, 32'hFFFF_FFFF);
        check(lat == 1, "R3 disabled latency", 32'(lat), 32'd1);
        io_access(1'b1, P_DATA, 4'hF, 32'h0BAD_0BAD, rd, ab, lat);
        check(starts == s0, "R3 no transaction started", 32'(starts), 32'(s0));
        io_access(1'b0, P_ADDR, 4'hF, '0, rd, ab, lat);
        check(rd == mk_addr(0, 0, 1, 0, 0), "R3 write had no effect", rd,
              mk_addr(0, 0, 1, 0, 0));
    endtask

    task automatic t_read_bus0();
        logic [31:0] rd; logic ab; int lat;
        io_access(1'b1, P_ADDR, 4'hF, mk_addr(1, 0, 5, 3, 6'h11), rd, ab, lat);
        ack_dly = 2; resp_data = 32'hCAFE_F00D;
        io_access(1'b0, P_DATA, 4'b1100, '0, rd, ab, lat);
        check(rd == 32'hCAFE_F00D && !ab, "R7 read data returned", rd, 32'hCAFE_F00D);
        check({c_wr, c_bus, c_dev, c_fn, c_reg, c_be} ==
              {1'b0, 8'd0, 5'd5, 3'd3, 6'h11, 4'b1100}, "R4 read fields",
              {7'd0, c_wr, c_bus, c_dev, c_fn, c_reg, c_be},
              {7'd0, 1'b0, 8'd0, 5'd5, 3'd3, 6'h11, 4'b1100});
        check(c_idsel == 32'h0000_0020 && !c_type1, "R5 idsel dev 5", c_idsel, 32'h20);
        check(!cfg_req, "R7 request dropped", {31'd0, cfg_req}, 32'h0);
    endtask

    task automatic t_write_bus0();
        logic [31:0] rd; logic ab; int lat;
        io_access(1'b1, P_ADDR, 4'hF, mk_addr(1, 0, 31, 0, 6'h3F), rd, ab, lat);
        ack_dly = 0;
        io_access(1'b1, P_DATA, 4'b0110, 32'hA5A5_5A5A, rd, ab, lat);
        check(c_wr && c_wdata == 32'hA5A5_5A5A && c_be == 4'b0110, "R4 write fields",
              c_wdata, 32'hA5A5_5A5A);
        check(c_idsel == 32'h8000_0000, "R5 idsel dev 31", c_idsel, 32'h8000_0000);
        check(!ab && lat == 2, "R7 immediate ack", 32'(lat), 32'd2);
    endtask

    task automatic t_type1();
        logic [31:0] rd; logic ab; int lat;
        io_access(1'b1, P_ADDR, 4'hF, mk_addr(1, 3, 2, 1, 4), rd, ab, lat);
        ack_dly = 1; resp_data = 32'h1111_2222;
        io_access(1'b0, P_DATA, 4'hF, '0, rd, ab, lat);
        check(c_type1 && c_idsel == '0, "R6 forward flag, no select", c_idsel, 32'h0);
        check(c_bus == 8'd3, "R6 bus carried", {24'd0, c_bus}, 32'd3);
        check(rd == 32'h1111_2222, "R7 type1 read data", rd, 32'h1111_2222);
    endtask

    task automatic t_window();
        logic [31:0] rd; logic ab; int lat;
        io_access(1'b1, P_ADDR, 4'hF, mk_addr(1, 0, 9, 0, 2), rd, ab, lat);
        ack_dly = 4; resp_data = 32'h5EED_0004;
        io_access(1'b0, P_DATA, 4'hF, '0, rd, ab, lat);
        check(rd == 32'h5EED_0004 && !ab, "R7 ack in last cycle", rd, 32'h5EED_0004);
        ack_dly = 5;
        io_access(1'b0, P_DATA, 4'hF, '0, rd, ab, lat);
        check(ab && rd == 32'hFFFF_FFFF, "R8 abort read all ones", rd, 32'hFFFF_FFFF);
        check(req_cycles == 5, "R8 request held 5 cycles", 32'(req_cycles), 32'd5);
        check(lat == 6, "R8 abort latency", 32'(lat), 32'd6);
        ack_dly = 99;
        io_access(1'b1, P_DATA, 4'hF, 32'h7777_7777, rd, ab, lat);
        check(ab == 1'b1, "R8 write abort", {31'd0, ab}, 32'd1);
        @(negedge clk);
        check(!io_done, "R9 done is one pulse", {31'd0, io_done}, 32'd0);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr_reg();
        t_disabled();
        t_read_bus0();
        t_write_bus0();
        t_type1();
        t_window();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule